// File: doc/BRIEF.md
# Triggered Noise and Triangle Overlay Generator

This block serves one analog output channel. It sits between the holding value that software or a DMA engine loads and the output register that drives the converter. When a trigger arrives, the output register takes the held value plus a generated waveform. The waveform is either pseudo-random noise from a 12-bit LFSR or a triangle ramp. The sum wraps at 12 bits.

A 4-bit size field sets the amplitude. In noise mode it sets how many LFSR bits pass through. In triangle mode it sets the exponent of the peak. The field can be written only while the channel is disabled. The generators move only on accepted triggers. Disabling the channel returns them to their starting state.

When triggering is turned off, the held value goes straight to the output and no waveform is added.

Top module: `overlay_wavegen`

## Requirements
- R1: After synchronous reset, `out_val` is 0 and the size field is 0.
- R2: While `chan_en` is low, `out_val` reads 0 from the next cycle. The LFSR returns to the seed 12'hACE and the triangle returns to 0, counting up.
- R3: While `chan_en` is high and `trig_en` is low, `out_val` takes `hold_val` one cycle later and no waveform is added.
- R4: The mode encoding is 2'b00 off, 2'b01 noise, and 2'b10 or 2'b11 triangle. In off mode an accepted trigger loads `hold_val` unchanged.
- R5: In triangle mode the waveform starts at 0. It rises by one per accepted trigger up to the peak, then falls by one per trigger back to 0, and repeats. Each trigger uses the waveform value held before that trigger's step.
- R6: The triangle peak is 2^n - 1, where n is the size field. A field value above 11 gives a peak of 4095.
- R7: In noise mode the LFSR state shifts toward the MSB. The new LSB is the XOR of state bits 11, 5, 3 and 0 (x^12+x^6+x^4+x+1). The waveform is the lowest k state bits, with k = field + 1; a field value above 11 gives k = 12.
- R8: `out_val` is (`hold_val` + waveform) mod 4096. The sum does not saturate.
- R9: An `amp_wr` strobe loads `amp_in` only in a cycle where `chan_en` is low. A write in any cycle where `chan_en` is high is ignored, including the cycle in which `chan_en` first rises.
- R10: An accepted trigger is `trig` high while both `chan_en` and `trig_en` are high. It updates `out_val` one cycle later and steps only the generator of the active mode. Without an accepted trigger, neither generator moves, and with `trig_en` high `out_val` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel enable; locks the size field |
| trig_en | input | 1 | Trigger mode enable |
| trig | input | 1 | Single-cycle trigger pulse |
| mode | input | 2 | Waveform mode select |
| amp_wr | input | 1 | Size field write strobe |
| amp_in | input | 4 | Size field write data |
| hold_val | input | 12 | Held DC value |
| out_val | output | 12 | Output register: held value plus waveform |

## Verification
A size field write can land in the same cycle that the channel becomes enabled, so the field lock and the enable decision meet on one clock edge. The bench raises `amp_wr` with a new value in the very cycle `chan_en` rises, and writes again later while the channel runs. It then reads the triangle sequence at the output. The write is judged ignored only if the ramp turns at the peak given by the field written earlier, while the channel was disabled. The bench also confirms that triggers pulsed while trigger mode is off leave the noise sequence starting from the seed.

// File: rtl/wg_pkg.sv
package wg_pkg;

    localparam int DATA_W  = 12;
    localparam int FIELD_W = 4;

    typedef logic [DATA_W-1:0]  sample_t;
    typedef logic [FIELD_W-1:0] field_t;

    typedef enum logic [1:0] {
        WG_OFF     = 2'b00,
        WG_NOISE   = 2'b01,
        WG_TRI     = 2'b10,
        WG_TRI_ALT = 2'b11
    } wg_mode_e;

    typedef struct packed {
        logic    up;
        sample_t cnt;
    } tri_state_t;

    // Peak of the triangle: 2^n - 1, n capped at full scale.
    function automatic sample_t peak_of(field_t f);
        logic [DATA_W:0] one;
        int n;
        n   = (int'(f) > DATA_W) ? DATA_W : int'(f);
        one = 1;
        one = one << n;
        return sample_t'(one - 1'b1);
    endfunction

    // Noise mask: the lowest field+1 bits, capped at full scale.
    function automatic sample_t mask_of(field_t f);
        logic [DATA_W:0] one;
        int k;
        k   = (int'(f) >= DATA_W - 1) ? DATA_W : int'(f) + 1;
        one = 1;
        one = one << k;
        return sample_t'(one - 1'b1);
    endfunction

    // Fibonacci step for x^12 + x^6 + x^4 + x + 1.
    function automatic sample_t lfsr_next(sample_t s);
        return {s[DATA_W-2:0], s[11] ^ s[5] ^ s[3] ^ s[0]};
    endfunction

endpackage

// File: rtl/wg_field_lock.sv
module wg_field_lock
    import wg_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   locked,
    input  logic   wr,
    input  field_t din,
    output field_t field_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            field_q <= '0;
        end else if (wr && !locked) begin
            field_q <= din;
        end
    end
endmodule

// File: rtl/wg_lfsr.sv
module wg_lfsr
    import wg_pkg::*;
#(
    parameter sample_t SEED = 12'hACE
)(
    input  logic    clk,
    input  logic    rst,
    input  logic    clr,
    input  logic    step,
    output sample_t state_q
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            state_q <= SEED;
        end else if (step) begin
            state_q <= lfsr_next(state_q);
        end
    end
endmodule

// File: rtl/wg_tri.sv
module wg_tri
    import wg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    clr,
    input  logic    step,
    input  sample_t peak,
    output sample_t cnt_q
);
    tri_state_t st_q;
    tri_state_t st_d;

    always_comb begin
        st_d = st_q;
        if (peak != '0) begin
            if (st_q.up) begin
                if (st_q.cnt >= peak) begin
                    st_d.up  = 1'b0;
                    st_d.cnt = st_q.cnt - 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end else begin
                if (st_q.cnt == '0) begin
                    st_d.up  = 1'b1;
                    st_d.cnt = st_q.cnt + 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            st_q <= '{up: 1'b1, cnt: '0};
        end else if (step) begin
            st_q <= st_d;
        end
    end

    assign cnt_q = st_q.cnt;
endmodule

// File: rtl/overlay_wavegen.sv
module overlay_wavegen
    import wg_pkg::*;
#(
    parameter logic [11:0] SEED = 12'hACE
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        chan_en,
    input  logic        trig_en,
    input  logic        trig,
    input  logic [1:0]  mode,
    input  logic        amp_wr,
    input  logic [3:0]  amp_in,
    input  logic [11:0] hold_val,
    output logic [11:0] out_val
);
    wg_mode_e mode_e;
    field_t   amp_q;
    sample_t  lfsr_q;
    sample_t  tri_cnt;
    sample_t  wave;
    logic     accept;

    assign mode_e = wg_mode_e'(mode);
    assign accept = chan_en && trig_en && trig;

    wg_field_lock u_lock (
        .clk     (clk),
        .rst     (rst),
        .locked  (chan_en),
        .wr      (amp_wr),
        .din     (amp_in),
        .field_q (amp_q)
    );

    wg_lfsr #(.SEED(SEED)) u_lfsr (
        .clk     (clk),
        .rst     (rst),
        .clr     (!chan_en),
        .step    (accept && (mode_e == WG_NOISE)),
        .state_q (lfsr_q)
    );

    wg_tri u_tri (
        .clk   (clk),
        .rst   (rst),
        .clr   (!chan_en),
        .step  (accept && mode[1]),
        .peak  (peak_of(amp_q)),
        .cnt_q (tri_cnt)
    );

    always_comb begin
        unique case (mode_e)
            WG_NOISE:          wave = lfsr_q & mask_of(amp_q);
            WG_TRI, WG_TRI_ALT: wave = tri_cnt;
            default:           wave = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !chan_en) begin
            out_val <= '0;
        end else if (!trig_en) begin
            out_val <= hold_val;
        end else if (trig) begin
            out_val <= hold_val + wave;
        end
    end
endmodule

// File: rtl/wg_checker.sv
module wg_checker
    import wg_pkg::*;
#(
    parameter logic [11:0] SEED = 12'hACE
)(
    input logic        clk,
    input logic        rst,
    input logic        chan_en,
    input logic        trig_en,
    input logic        trig,
    input logic [1:0]  mode,
    input logic [11:0] hold_val,
    input logic [11:0] out_val,
    input logic [3:0]  amp_q,
    input logic [11:0] lfsr_q,
    input logic [11:0] tri_cnt
);
    // R2
    disabled_clears_chk: assert property (@(posedge clk) disable iff (rst)
        !chan_en |=> (out_val == 12'd0 && tri_cnt == 12'd0 && lfsr_q == SEED));

    // R3
    direct_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (chan_en && !trig_en) |=> (out_val == $past(hold_val)));

    // R4
    off_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (chan_en && trig_en && trig && mode == 2'b00) |=> (out_val == $past(hold_val)));

    // R9
    field_lock_chk: assert property (@(posedge clk) disable iff (rst)
        chan_en |=> $stable(amp_q));

    // R10
    gen_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (chan_en && !(trig_en && trig)) |=> ($stable(lfsr_q) && $stable(tri_cnt)));

    // R10
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (chan_en && trig_en && !trig) |=> $stable(out_val));

    // R6
    tri_bound_chk: assert property (@(posedge clk) disable iff (rst)
        tri_cnt <= peak_of(amp_q));

    // R7
    lfsr_live_chk: assert property (@(posedge clk) disable iff (rst)
        lfsr_q != 12'd0);
endmodule

bind overlay_wavegen wg_checker #(.SEED(SEED)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .chan_en  (chan_en),
    .trig_en  (trig_en),
    .trig     (trig),
    .mode     (mode),
    .hold_val (hold_val),
    .out_val  (out_val),
    .amp_q    (amp_q),
    .lfsr_q   (lfsr_q),
    .tri_cnt  (tri_cnt)
);

// File: tb/overlay_wavegen_tb.sv
module overlay_wavegen_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        chan_en = 1'b0;
    logic        trig_en = 1'b0;
    logic        trig = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic        amp_wr = 1'b0;
    logic [3:0]  amp_in = 4'd0;
    logic [11:0] hold_val = 12'd0;
    logic [11:0] out_val;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [11:0] m_lfsr;
    logic [11:0] m_cnt;
    logic        m_up;
    logic [3:0]  m_amp;

    overlay_wavegen u_dut (
        .clk(clk), .rst(rst), .chan_en(chan_en), .trig_en(trig_en),
        .trig(trig), .mode(mode), .amp_wr(amp_wr), .amp_in(amp_in),
        .hold_val(hold_val), .out_val(out_val)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] m_peak(input logic [3:0] f);
        int n = (f > 4'd12) ? 12 : int'(f);
        return 12'((13'd1 << n) - 13'd1);
    endfunction

    function automatic logic [11:0] m_mask(input logic [3:0] f);
        int k = (f >= 4'd11) ? 12 : int'(f) + 1;
        return 12'((13'd1 << k) - 13'd1);
    endfunction

    task automatic model_reset();
        m_lfsr = 12'hACE;
        m_cnt  = 12'd0;
        m_up   = 1'b1;
    endtask

    // Expected wave for the next accepted trigger, then advance the model.
    task automatic model_fire(output logic [11:0] w);
        logic [11:0] pk;
        if (mode == 2'b01) begin
            w = m_lfsr & m_mask(m_amp);
            m_lfsr = {m_lfsr[10:0], m_lfsr[11] ^ m_lfsr[5] ^ m_lfsr[3] ^ m_lfsr[0]};
        end else if (mode[1]) begin
            w  = m_cnt;
            pk = m_peak(m_amp);
            if (pk != 0) begin
                if (m_up && m_cnt == pk) begin m_up = 1'b0; m_cnt = m_cnt - 1; end
                else if (!m_up && m_cnt == 0) begin m_up = 1'b1; m_cnt = m_cnt + 1; end
                else if (m_up) m_cnt = m_cnt + 1;
                else m_cnt = m_cnt - 1;
            end
        end else begin
            w = 12'd0;
        end
    endtask

    task automatic fire_check(input string req);
        logic [11:0] w;
        model_fire(w);
        @(negedge clk) trig = 1'b1;
        @(negedge clk) trig = 1'b0;
        check(req, out_val, hold_val + w);
    endtask

    task automatic write_field(input logic [3:0] v);
        @(negedge clk) begin chan_en = 1'b0; amp_wr = 1'b1; amp_in = v; end
        @(negedge clk) amp_wr = 1'b0;
        m_amp = v;
        model_reset();
    endtask

    task automatic enable_run(input logic [1:0] md);
        @(negedge clk) begin mode = md; chan_en = 1'b1; trig_en = 1'b1; end
    endtask

    task automatic t_reset();
        @(negedge clk) check("R1 reset output", out_val, 12'd0);
        m_amp = 4'd0;
        model_reset();
        hold_val = 12'h200;
        enable_run(2'b10);
        fire_check("R1 reset field gives peak 0");
        fire_check("R1 reset field gives peak 0");
    endtask

    task automatic t_direct();
        write_field(4'd4);
        @(negedge clk) begin chan_en = 1'b1; trig_en = 1'b0; mode = 2'b01; hold_val = 12'h123; end
        @(negedge clk) check("R3 direct transfer", out_val, 12'h123);
        hold_val = 12'h456;
        @(negedge clk) trig = 1'b1;
        @(negedge clk) trig = 1'b0;
        check("R3 direct transfer, trigger ignored", out_val, 12'h456);
        @(negedge clk) trig_en = 1'b1;
        fire_check("R10 noise starts at seed after untaken triggers");
        @(negedge clk);
        check("R10 output holds without trigger", out_val, 12'h456 + (12'hACE & 12'h01F));
    endtask

    task automatic t_off();
        write_field(4'd9);
        hold_val = 12'h7A5;
        enable_run(2'b00);
        fire_check("R4 off mode passes held value");
        hold_val = 12'h011;
        fire_check("R4 off mode passes held value");
    endtask

    task automatic t_tri();
        write_field(4'd2);
        hold_val = 12'h100;
        enable_run(2'b10);
        for (int i = 0; i < 10; i++) fire_check("R5 triangle peak 3");
        @(negedge clk) mode = 2'b11;
        for (int i = 0; i < 3; i++) fire_check("R4 alternate triangle code");
    endtask

    task automatic t_full();
        logic [11:0] w;
        write_field(4'd15);
        hold_val = 12'd0;
        enable_run(2'b10);
        for (int i = 0; i < 4095; i++) model_fire(w);
        @(negedge clk) trig = 1'b1;
        repeat (4095) @(negedge clk);
        trig = 1'b0;
        check("R6 field above 11 ramps to 4095 (before top)", out_val, 12'd4094);
        fire_check("R6 field above 11 reaches 4095");
        fire_check("R6 field above 11 turns down");
    endtask

    task automatic t_wrap();
        write_field(4'd2);
        hold_val = 12'hFFE;
        enable_run(2'b10);
        for (int i = 0; i < 4; i++) fire_check("R8 sum wraps mod 4096");
    endtask

    task automatic t_noise(input logic [3:0] f);
        write_field(f);
        hold_val = 12'h100;
        enable_run(2'b01);
        for (int i = 0; i < 8; i++) fire_check("R7 noise masked");
    endtask

    task automatic t_lock();
        write_field(4'd1);
        hold_val = 12'h040;
        @(negedge clk) begin mode = 2'b10; chan_en = 1'b1; trig_en = 1'b1; amp_wr = 1'b1; amp_in = 4'd3; end
        @(negedge clk) amp_wr = 1'b0;
        @(negedge clk) begin amp_wr = 1'b1; amp_in = 4'd5; end
        @(negedge clk) amp_wr = 1'b0;
        for (int i = 0; i < 5; i++) fire_check("R9 write while enabled ignored, peak 1");
        write_field(4'd3);
        enable_run(2'b10);
        for (int i = 0; i < 5; i++) fire_check("R9 write while disabled taken, peak 7");
    endtask

    task automatic t_disable();
        write_field(4'd3);
        hold_val = 12'h300;
        enable_run(2'b10);
        for (int i = 0; i < 3; i++) fire_check("R5 ramp before disable");
        @(negedge clk) chan_en = 1'b0;
        @(negedge clk) check("R2 disabled output zero", out_val, 12'd0);
        model_reset();
        enable_run(2'b10);
        fire_check("R2 triangle restarts at 0");
        fire_check("R2 triangle restarts at 0");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_direct();
        t_off();
        t_tri();
        t_wrap();
        t_noise(4'd0);
        t_noise(4'd3);
        t_noise(4'd11);
        t_lock();
        t_disable();
        t_full();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule